// File: doc/BRIEF.md
# Access-Unit Timestamp Scheduler

This block schedules the decode and presentation moments of a stream of coded access units against a free-running 33-bit system time base that counts at 90 kHz. An upstream parser hands over one descriptor per access unit. The descriptor may carry a presentation time, a decode time, or neither. It also carries a flag that marks reordered reference pictures. The block works out both times for every unit. It adds a programmable latency offset to each time and holds the unit in a short queue. When the time base reaches a unit's decode target, the block emits a one-cycle decode strobe. When the time base reaches the unit's presentation target, it emits a one-cycle presentation strobe.

Units that carry no timestamps get their times from the previous unit's times plus a programmable per-unit increment. The typical increment is 3003 ticks for 29.97 Hz video. A discontinuity pulse discards this history, so that the next coded timestamp becomes the new reference. The block also watches the spacing of coded presentation times. If the forward distance between two coded values exceeds a limit (63000 ticks by default, which is 700 ms), it raises a sticky error.

Top module: `pts_sched`

## Requirements
- R1: A unit whose has-PTS flag is 1 and whose DTS is not used takes its coded PTS as both its decode time and its presentation time.
- R2: The coded DTS is used as the decode time only when the has-PTS, has-DTS and reference-picture flags are all 1. In every other case the DTS field has no effect.
- R3: A unit with has-PTS at 0 takes the previous queued unit's decode and presentation times, each plus `unit_incr`, modulo 2^33. If there is no history since reset or since the last discontinuity, the unit is accepted and dropped, and it produces no strobes.
- R4: The value of `lat_offset` at the moment a unit is accepted is added, modulo 2^33, to both of that unit's times. The sums are the unit's targets and are reported on `dec_time` and `pres_time`.
- R5: A target counts as reached when (stc - target) mod 2^33 is less than 2^32. This comparison stays correct across the wrap of the time base.
- R6: The queue head gets exactly one `dec_stb` pulse, in the cycle after its decode target is reached. It then gets one `pres_stb` pulse, in the cycle after its presentation target is reached, and this pulse comes at least one cycle after the decode pulse. The head is released with the presentation pulse, and units are served in arrival order.
- R7: `gap_err` goes to 1 in the cycle after a coded PTS is accepted whose forward distance from the previous coded PTS is below 2^32 and greater than `GAP_MAX`. A gap equal to `GAP_MAX`, or a backward step, leaves it unchanged. Once set, it stays at 1 until reset.
- R8: While `disc` is 1, the interpolation history and the gap reference are cleared. A unit accepted in the same cycle sees them already empty.
- R9: The queue holds `DEPTH` units. `in_ready` is 0 exactly while `DEPTH` units are held, and a descriptor is taken only when `in_valid` and `in_ready` are both 1.
- R10: After reset, both strobes and `gap_err` are 0, `in_ready` is 1 and the history is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stc | input | 33 | Current 90 kHz system time base |
| lat_offset | input | 33 | Latency offset added to every timestamp |
| unit_incr | input | 33 | Per-unit increment for interpolation |
| disc | input | 1 | Time base discontinuity, clears history |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Queue can take a descriptor |
| in_has_pts | input | 1 | Descriptor carries a PTS |
| in_has_dts | input | 1 | Descriptor carries a DTS |
| in_ref_pic | input | 1 | Reordered reference picture |
| in_pts | input | 33 | Coded presentation time |
| in_dts | input | 33 | Coded decode time |
| dec_stb | output | 1 | Decode strobe for the queue head |
| dec_time | output | 33 | Target of the last decode strobe |
| pres_stb | output | 1 | Presentation strobe, releases the head |
| pres_time | output | 33 | Target of the last presentation strobe |
| gap_err | output | 1 | Sticky PTS spacing violation |

## Verification
The hardest case to reach from the ports is a gap check that has to be ignored, because a discontinuity has cleared the reference. To set this up, the stimulus first drains the queue. It then jumps the time base forward by far more than the gap limit and pulses `disc` in the same cycle as an untimed unit, which has to be dropped. Only after that does it send a coded unit. The stimulus also places the time base just below 2^33, so that interpolated targets and the reached test wrap through zero. A unit whose targets are already in the past checks that the strobes fire at once.

// File: rtl/pts_sched_pkg.sv
package pts_sched_pkg;
    localparam int TS_W = 33;

    typedef logic [TS_W-1:0] ts_t;

    typedef struct packed {
        ts_t dts;
        ts_t pts;
    } unit_t;

    // Target reached when the modular distance now - tgt is in the lower half.
    function automatic logic ts_reached(ts_t now, ts_t tgt);
        ts_t d;
        d = now - tgt;
        return ~d[TS_W-1];
    endfunction
endpackage

// File: rtl/pts_resolve.sv
module pts_resolve
    import pts_sched_pkg::*;
#(
    parameter int GAP_MAX = 63000
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  disc,
    input  logic  accept,
    input  logic  has_pts,
    input  logic  has_dts,
    input  logic  ref_pic,
    input  ts_t   pts,
    input  ts_t   dts,
    input  ts_t   incr,
    input  ts_t   offset,
    output logic  push,
    output unit_t ent,
    output logic  gap_err
);
    typedef struct packed {
        logic hist_v;
        ts_t  hist_dts;
        ts_t  hist_pts;
        logic ref_v;
        ts_t  ref_pts;
        logic err;
    } res_st_t;

    res_st_t st_d, st_q;
    logic    hist_ok, ref_ok;
    ts_t     raw_pts, raw_dts, gap;

    always_comb begin
        st_d    = st_q;
        hist_ok = st_q.hist_v & ~disc;
        ref_ok  = st_q.ref_v & ~disc;
        raw_pts = has_pts ? pts : st_q.hist_pts + incr;
        raw_dts = has_pts ? ((has_dts & ref_pic) ? dts : pts) : st_q.hist_dts + incr;
        gap     = pts - st_q.ref_pts;
        push    = accept & (has_pts | hist_ok);

        if (disc) begin
            st_d.hist_v = 1'b0;
            st_d.ref_v  = 1'b0;
        end
        if (push) begin
            st_d.hist_v   = 1'b1;
            st_d.hist_dts = raw_dts;
            st_d.hist_pts = raw_pts;
        end
        if (accept && has_pts) begin
            st_d.ref_v   = 1'b1;
            st_d.ref_pts = pts;
            if (ref_ok && !gap[TS_W-1] && gap > ts_t'(GAP_MAX))
                st_d.err = 1'b1;
        end

        ent.dts = raw_dts + offset;
        ent.pts = raw_pts + offset;
        gap_err = st_q.err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pts_queue.sv
module pts_queue
    import pts_sched_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  logic  pop,
    input  unit_t wdata,
    output unit_t head,
    output logic  empty,
    output logic  full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        unit_t [DEPTH-1:0] mem;
        logic  [PW-1:0]    rd;
        logic  [PW-1:0]    wr;
        logic  [CW-1:0]    cnt;
    } q_st_t;

    q_st_t st_d, st_q;
    logic  push_ok, pop_ok;

    function automatic logic [PW-1:0] ptr_next(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        empty   = (st_q.cnt == '0);
        full    = (st_q.cnt == CW'(DEPTH));
        head    = st_q.mem[st_q.rd];
        push_ok = push & ~full;
        pop_ok  = pop & ~empty;

        if (push_ok) begin
            st_d.mem[st_q.wr] = wdata;
            st_d.wr           = ptr_next(st_q.wr);
        end
        if (pop_ok)
            st_d.rd = ptr_next(st_q.rd);

        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pts_sched.sv
module pts_sched
    import pts_sched_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int GAP_MAX = 63000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TS_W-1:0] stc,
    input  logic [TS_W-1:0] lat_offset,
    input  logic [TS_W-1:0] unit_incr,
    input  logic            disc,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic            in_has_pts,
    input  logic            in_has_dts,
    input  logic            in_ref_pic,
    input  logic [TS_W-1:0] in_pts,
    input  logic [TS_W-1:0] in_dts,
    output logic            dec_stb,
    output logic [TS_W-1:0] dec_time,
    output logic            pres_stb,
    output logic [TS_W-1:0] pres_time,
    output logic            gap_err
);
    typedef struct packed {
        logic dec_done;
        logic dec_stb;
        ts_t  dec_time;
        logic pres_stb;
        ts_t  pres_time;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    accept, push, pop, q_empty, q_full;
    logic    dec_fire, pres_fire;
    unit_t   new_unit, head;

    pts_resolve #(.GAP_MAX(GAP_MAX)) u_resolve (
        .clk     (clk),
        .rst_n   (rst_n),
        .disc    (disc),
        .accept  (accept),
        .has_pts (in_has_pts),
        .has_dts (in_has_dts),
        .ref_pic (in_ref_pic),
        .pts     (in_pts),
        .dts     (in_dts),
        .incr    (unit_incr),
        .offset  (lat_offset),
        .push    (push),
        .ent     (new_unit),
        .gap_err (gap_err)
    );

    pts_queue #(.DEPTH(DEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .wdata (new_unit),
        .head  (head),
        .empty (q_empty),
        .full  (q_full)
    );

    always_comb begin
        st_d      = st_q;
        in_ready  = ~q_full;
        accept    = in_valid & in_ready;
        dec_fire  = ~q_empty & ~st_q.dec_done & ts_reached(stc, head.dts);
        pres_fire = ~q_empty &  st_q.dec_done & ts_reached(stc, head.pts);
        pop       = pres_fire;

        st_d.dec_stb  = dec_fire;
        st_d.pres_stb = pres_fire;
        if (dec_fire) begin
            st_d.dec_done = 1'b1;
            st_d.dec_time = head.dts;
        end
        if (pres_fire) begin
            st_d.dec_done  = 1'b0;
            st_d.pres_time = head.pts;
        end

        dec_stb   = st_q.dec_stb;
        dec_time  = st_q.dec_time;
        pres_stb  = st_q.pres_stb;
        pres_time = st_q.pres_time;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pts_sched_chk.sv
module pts_sched_chk
    import pts_sched_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input ts_t  stc,
    input logic dec_stb,
    input ts_t  dec_time,
    input logic pres_stb,
    input ts_t  pres_time,
    input logic gap_err
);
    AST_DEC_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_stb |=> !dec_stb); // R6
    AST_NO_DEC_WITH_PRES: assert property (@(posedge clk) disable iff (!rst_n)
        pres_stb |-> !dec_stb); // R6
    AST_DEC_TARGET_REACHED: assert property (@(posedge clk) disable iff (!rst_n)
        dec_stb |-> ts_reached($past(stc), dec_time)); // R5
    AST_PRES_TARGET_REACHED: assert property (@(posedge clk) disable iff (!rst_n)
        pres_stb |-> ts_reached($past(stc), pres_time)); // R5
    AST_GAP_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        gap_err |=> gap_err); // R7
endmodule

bind pts_sched pts_sched_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stc       (stc),
    .dec_stb   (dec_stb),
    .dec_time  (dec_time),
    .pres_stb  (pres_stb),
    .pres_time (pres_time),
    .gap_err   (gap_err)
);

// File: tb/tb_pts_sched.sv
module tb_pts_sched;
    localparam int    CLK_PERIOD = 10;
    localparam int    DEPTH      = 4;
    localparam int    GAP_MAX    = 63000;
    localparam int    STEP       = 100;
    localparam longint M    = (64'd1 << 33) - 1;
    localparam longint HALF = 64'd1 << 32;

    logic        clk = 0, rst_n = 0;
    logic [32:0] stc = 33'd1000, lat_offset = 33'd500, unit_incr = 33'd3003;
    logic        disc = 0, in_valid = 0, in_has_pts = 0, in_has_dts = 0, in_ref_pic = 0;
    logic [32:0] in_pts = 0, in_dts = 0;
    logic        in_ready, dec_stb, pres_stb, gap_err;
    logic [32:0] dec_time, pres_time;

    int    checks = 0, errors = 0, cycles = 0;
    string phase = "R10 reset";

    pts_sched #(.DEPTH(DEPTH), .GAP_MAX(GAP_MAX)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    typedef struct { longint d; longint p; } mu_t;
    mu_t    q[$];
    bit     m_done, hv, rv, started;
    longint hd, hp, rp;
    bit     e_dec, e_pres, e_err, e_ready;
    longint e_dtime, e_ptime;

    function automatic bit mreach(longint now, longint t);
        return ((now - t) & M) < HALF;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); m_done = 0; hv = 0; rv = 0; hd = 0; hp = 0; rp = 0;
            e_dec = 0; e_pres = 0; e_err = 0; e_ready = 1; e_dtime = 0; e_ptime = 0;
        end else begin
            bit acc, hok, rok, ready;
            longint p, d, gap;
            started = 1;
            ready = q.size() < DEPTH;
            e_dec = 0; e_pres = 0;
            if (q.size() > 0) begin
                if (!m_done && mreach(longint'(stc), q[0].d)) begin
                    e_dec = 1; e_dtime = q[0].d; m_done = 1;
                end else if (m_done && mreach(longint'(stc), q[0].p)) begin
                    e_pres = 1; e_ptime = q[0].p; void'(q.pop_front()); m_done = 0;
                end
            end
            acc = in_valid && ready;
            hok = hv && !disc;
            rok = rv && !disc;
            if (disc) begin hv = 0; rv = 0; end
            if (acc) begin
                if (in_has_pts) begin
                    p = longint'(in_pts);
                    d = (in_has_dts && in_ref_pic) ? longint'(in_dts) : p;
                    gap = (p - rp) & M;
                    if (rok && gap < HALF && gap > GAP_MAX) e_err = 1;
                    rp = p; rv = 1;
                end else begin
                    p = (hp + longint'(unit_incr)) & M;
                    d = (hd + longint'(unit_incr)) & M;
                end
                if (in_has_pts || hok) begin
                    hp = p; hd = d; hv = 1;
                    q.push_back('{d: (d + longint'(lat_offset)) & M,
                                  p: (p + longint'(lat_offset)) & M});
                end
            end
            e_ready = q.size() < DEPTH;
        end
    end

    // ---------------- per-cycle comparison ----------------
    task automatic cmp(string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL [%s] %s: actual %0d expected %0d at %0t", phase, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (started) begin
            cmp("in_ready (R9)", in_ready, e_ready);
            cmp("dec_stb (R6)", dec_stb, e_dec);
            cmp("pres_stb (R6)", pres_stb, e_pres);
            cmp("gap_err (R7)", gap_err, e_err);
            if (e_dec)  cmp("dec_time (R1/R2/R3/R4)", dec_time, e_dtime);
            if (e_pres) cmp("pres_time (R1/R3/R4)", pres_time, e_ptime);
        end
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(int n = 1);
        repeat (n) begin
            @(negedge clk);
            stc = stc + 33'(STEP);
        end
    endtask

    task automatic send(bit hp_i, bit hd_i, bit rf_i, logic [32:0] p_i, logic [32:0] d_i);
        while (!in_ready) tick();
        in_valid = 1; in_has_pts = hp_i; in_has_dts = hd_i; in_ref_pic = rf_i;
        in_pts = p_i; in_dts = d_i;
        tick();
        in_valid = 0; in_has_pts = 0; in_has_dts = 0; in_ref_pic = 0;
    endtask

    initial begin
        logic [32:0] x;
        tick(4);
        rst_n = 1;
        tick(3);

        phase = "R3 uncoded unit with empty history is dropped";
        send(0, 0, 0, 33'd0, 33'd0);
        tick(20);

        phase = "R1 PTS only, R6 strobe order";
        send(1, 0, 0, stc + 33'd2000, 33'd0);
        tick(40);

        phase = "R2 reordered reference and ignored DTS";
        send(1, 1, 1, stc + 33'd3000, stc + 33'd1000);
        send(1, 1, 0, stc + 33'd4000, stc + 33'd50);
        send(1, 1, 1, stc + 33'd4100, 33'd7);
        tick(80);

        phase = "R3 interpolation";
        send(0, 0, 0, 33'd0, 33'd0);
        send(0, 0, 0, 33'd0, 33'd0);
        send(0, 0, 0, 33'd0, 33'd0);
        tick(200);

        phase = "R4 offset change";
        lat_offset = 33'd2000;
        send(1, 0, 0, stc + 33'd500, 33'd0);
        send(0, 0, 0, 33'd0, 33'd0);
        tick(90);

        phase = "R9 queue full and order";
        for (int i = 0; i < 6; i++) send(1, 0, 0, stc + 33'd5000 + 33'(i * 300), 33'd0);
        tick(160);

        phase = "R8 discontinuity";
        stc = stc + 33'd200000;
        disc = 1;
        send(0, 0, 0, 33'd0, 33'd0);
        disc = 0;
        x = stc + 33'd1000;
        send(1, 0, 0, x, 33'd0);
        send(0, 0, 0, 33'd0, 33'd0);
        tick(100);

        phase = "R7 PTS gap limit";
        send(1, 0, 0, x + 33'd63000, 33'd0);
        send(1, 0, 0, x + 33'd58000, 33'd0);
        send(1, 0, 0, x + 33'd121001, 33'd0);
        tick(1400);

        phase = "R5 wrap of time base";
        stc = 33'h1_FFFF_F448;
        send(1, 0, 0, 33'h1_FFFF_FC18, 33'd0);
        send(0, 0, 0, 33'd0, 33'd0);
        send(1, 0, 0, stc - 33'd10000, 33'd0);
        tick(150);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule